// File: doc/BRIEF.md
# DMA Transfer Master Sequencer

This block runs one DMA data move as a bus master. A command carries a byte count of up to 4 KB, a start address, a wrap address, a direction and a completion mode. Both addresses are forced to 32-bit word alignment. The block then issues word-wide read or write requests on a request/ready/error handshake. It steps the address by one word per accepted beat. When the next address would equal the wrap point, it folds back to the start address. It also counts the remaining bytes down.

When the count is used up, the block does one of two things. It sets a sticky completion interrupt and waits for the next command, or it pulses a request to a descriptor-fetch unit to load the next descriptor. If a beat draws an error response, the sequencer freezes and raises a sticky error interrupt. It stays frozen until software clears that interrupt. It then issues the same address with the same direction again, and the transfer goes on from there.

Top module: `dma_xfer_master`

## Requirements
- R1: While rst_ni is low and right after it rises, bus_req_o, busy_o, done_irq_o, err_irq_o and desc_req_o are all 0.
- R2: A start_i pulse while idle loads the command. From the next cycle, bus_req_o is 1 with bus_addr_o equal to start_addr_i with bits [1:0] cleared, and bus_write_o equal to dir_i (1 = write, 0 = read).
- R3: Each beat accepted (bus_ready_i=1, bus_err_i=0 while bus_req_o=1) moves bus_addr_o up by 4. If that value equals wrap_addr_i with bits [1:0] cleared, the address becomes the aligned start address instead.
- R4: A transfer completes after ceil(count_i/4) accepted beats. A count_i of 0 completes in the cycle after start_i, and no request is issued.
- R5: When a transfer completes with chain_i=0, done_irq_o is 1 from the next cycle and stays set until a done_clr_i strobe. If a completion and done_clr_i fall in the same cycle, the flag ends up set.
- R6: When a transfer completes with chain_i=1, desc_req_o is 1 for exactly one cycle and done_irq_o is not set.
- R7: A beat answered with bus_err_i=1 is not accepted, even when bus_ready_i is also 1. In the next cycle err_irq_o is 1, bus_req_o is 0 and bus_addr_o keeps its value.
- R8: While suspended, an err_clr_i strobe clears err_irq_o. In the next cycle the block requests again with the same address and direction that drew the error.
- R9: A start_i while busy_o=1 is ignored. This holds during suspension as well.
- R10: While bus_req_o=1 and the beat is neither accepted nor errored, bus_req_o, bus_addr_o and bus_write_o hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command strobe, taken only when idle |
| count_i | input | 12 | Transfer length in bytes |
| start_addr_i | input | 32 | Start address, low two bits ignored |
| wrap_addr_i | input | 32 | Wrap address, low two bits ignored |
| dir_i | input | 1 | 1 = write beats, 0 = read beats |
| chain_i | input | 1 | 1 = request a descriptor at completion, 0 = interrupt |
| bus_req_o | output | 1 | Beat request |
| bus_write_o | output | 1 | Beat direction |
| bus_addr_o | output | 32 | Beat word address |
| bus_ready_i | input | 1 | Beat accepted |
| bus_err_i | input | 1 | Error response to the current beat |
| done_irq_o | output | 1 | Sticky completion interrupt |
| done_clr_i | input | 1 | Write-one-to-clear strobe for done_irq_o |
| err_irq_o | output | 1 | Sticky error interrupt |
| err_clr_i | input | 1 | Clear strobe for err_irq_o, releases suspension |
| desc_req_o | output | 1 | One-cycle descriptor fetch request |
| busy_o | output | 1 | Transfer in progress or suspended |

## Verification
Two same-cycle collisions matter here. The first is the completion of a transfer landing in the same cycle as a software done_clr_i strobe. The bench drives the clear strobe during the final accepted beat and expects done_irq_o to read 1 afterwards. The second is an error response arriving together with bus_ready_i. The bench raises both on the same beat and expects no address step, a suspended request and a set error flag, followed by a replay of that exact address once the error flag is cleared.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_HALT = 2'd2
  } xfer_state_e;

  localparam int unsigned IRQ_DONE = 0;
  localparam int unsigned IRQ_ERR  = 1;
  localparam int unsigned IRQ_N    = 2;
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] wrap_addr_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned LSB_W = $clog2(WORD_BYTES);

  logic [ADDR_W-1:0] base_q, wrap_q, addr_q, step_addr, start_al, wrap_al;

  assign start_al  = {start_addr_i[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
  assign wrap_al   = {wrap_addr_i[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
  assign step_addr = addr_q + ADDR_W'(WORD_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      wrap_q <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      base_q <= start_al;
      wrap_q <= wrap_al;
      addr_q <= start_al;
    end else if (adv_i) begin
      addr_q <= (step_addr == wrap_q) ? base_q : step_addr;
    end
  end

  assign addr_o = addr_q;

  // word alignment is kept for the whole transfer
  assert_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q[LSB_W-1:0] == '0);
endmodule

// File: rtl/dma_byte_cnt.sv
module dma_byte_cnt #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dec_i,
  output logic             load_zero_o,
  output logic             last_o,
  output logic             rem_zero_o
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (load_i) rem_q <= count_i;
    else if (dec_i)  rem_q <= last_o ? '0 : rem_q - CNT_W'(WORD_BYTES);
  end

  assign load_zero_o = (count_i == '0);
  // a partial last word still takes one beat
  assign last_o      = (rem_q <= CNT_W'(WORD_BYTES));
  assign rem_zero_o  = (rem_q == '0);
endmodule

// File: rtl/dma_irq_flag.sv
module dma_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
endmodule

// File: rtl/dma_xfer_master.sv
module dma_xfer_master
  import dma_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] wrap_addr_i,
  input  logic              dir_i,
  input  logic              chain_i,
  output logic              bus_req_o,
  output logic              bus_write_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_ready_i,
  input  logic              bus_err_i,
  output logic              done_irq_o,
  input  logic              done_clr_i,
  output logic              err_irq_o,
  input  logic              err_clr_i,
  output logic              desc_req_o,
  output logic              busy_o
);
  xfer_state_e st_q, st_d;
  logic dir_q, chain_q, desc_q;
  logic launch, accept, err_hit, finish, chain_eff;
  logic load_zero, last_beat, rem_zero;
  logic [IRQ_N-1:0] irq_set, irq_clr, irq_q;

  assign launch    = (st_q == ST_IDLE) && start_i;
  assign accept    = (st_q == ST_XFER) && bus_ready_i && !bus_err_i;
  assign err_hit   = (st_q == ST_XFER) && bus_err_i;
  assign finish    = (launch && load_zero) || (accept && last_beat);
  assign chain_eff = launch ? chain_i : chain_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (launch && !load_zero) st_d = ST_XFER;
      ST_XFER: begin
        if (err_hit)                st_d = ST_HALT;
        else if (accept && last_beat) st_d = ST_IDLE;
      end
      ST_HALT: if (err_clr_i) st_d = ST_XFER;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      dir_q   <= 1'b0;
      chain_q <= 1'b0;
      desc_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      desc_q <= finish && chain_eff;
      if (launch) begin
        dir_q   <= dir_i;
        chain_q <= chain_i;
      end
    end
  end

  dma_addr_gen #(
    .ADDR_W    (ADDR_W),
    .WORD_BYTES(WORD_BYTES)
  ) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (launch),
    .start_addr_i(start_addr_i),
    .wrap_addr_i (wrap_addr_i),
    .adv_i       (accept),
    .addr_o      (bus_addr_o)
  );

  dma_byte_cnt #(
    .CNT_W     (CNT_W),
    .WORD_BYTES(WORD_BYTES)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (launch),
    .count_i    (count_i),
    .dec_i      (accept),
    .load_zero_o(load_zero),
    .last_o     (last_beat),
    .rem_zero_o (rem_zero)
  );

  assign irq_set[IRQ_DONE] = finish && !chain_eff;
  assign irq_clr[IRQ_DONE] = done_clr_i;
  assign irq_set[IRQ_ERR]  = err_hit;
  assign irq_clr[IRQ_ERR]  = err_clr_i;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
    dma_irq_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (irq_set[g]),
      .clr_i (irq_clr[g]),
      .flag_o(irq_q[g])
    );
  end

  assign bus_req_o   = (st_q == ST_XFER);
  assign bus_write_o = dir_q;
  assign done_irq_o  = irq_q[IRQ_DONE];
  assign err_irq_o   = irq_q[IRQ_ERR];
  assign desc_req_o  = desc_q;
  assign busy_o      = (st_q != ST_IDLE);

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ready_i && !bus_err_i |=>
      bus_req_o && $stable(bus_addr_o) && $stable(bus_write_o));

  assert_err_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_err_i |=> !bus_req_o && err_irq_o && $stable(bus_addr_o));

  assert_replay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HALT) && err_clr_i |=>
      bus_req_o && !err_irq_o && $stable(bus_addr_o) && $stable(bus_write_o));

  assert_no_empty_xfer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_XFER) |-> !rem_zero);

  assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !bus_req_o |=> !bus_req_o || $past(err_clr_i));
endmodule

// File: tb/dma_xfer_master_tb.sv
`timescale 1ns/1ps
module dma_xfer_master_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, dir_i = 0, chain_i = 0;
  logic [11:0] count_i = '0;
  logic [31:0] start_addr_i = '0, wrap_addr_i = '0;
  logic bus_ready_i = 0, bus_err_i = 0, done_clr_i = 0, err_clr_i = 0;
  logic bus_req_o, bus_write_o, done_irq_o, err_irq_o, desc_req_o, busy_o;
  logic [31:0] bus_addr_o;

  always #4 clk_i = ~clk_i;

  dma_xfer_master u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .count_i(count_i),
    .start_addr_i(start_addr_i), .wrap_addr_i(wrap_addr_i), .dir_i(dir_i),
    .chain_i(chain_i), .bus_req_o(bus_req_o), .bus_write_o(bus_write_o),
    .bus_addr_o(bus_addr_o), .bus_ready_i(bus_ready_i), .bus_err_i(bus_err_i),
    .done_irq_o(done_irq_o), .done_clr_i(done_clr_i), .err_irq_o(err_irq_o),
    .err_clr_i(err_clr_i), .desc_req_o(desc_req_o), .busy_o(busy_o)
  );

  int total = 0, bad = 0, cyc = 0, rdy_mode = 0;
  string tag = "R1";

  // behavioural reference model
  bit m_busy, m_halt, m_dir, m_chain, m_done, m_err, m_desc;
  logic [31:0] m_addr, m_base, m_wrap;
  int m_rem, m_acc;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_halt = 0; m_done = 0; m_err = 0; m_desc = 0;
      m_addr = 0; m_rem = 0; m_acc = 0; m_dir = 0; m_chain = 0;
    end else begin
      bit fin;
      fin = 0;
      m_desc = 0;
      if (done_clr_i) m_done = 0;
      if (err_clr_i)  m_err = 0;
      if (!m_busy) begin
        if (start_i) begin
          m_base = start_addr_i & 32'hFFFF_FFFC;
          m_wrap = wrap_addr_i & 32'hFFFF_FFFC;
          m_addr = m_base;
          m_rem = int'(count_i);
          m_dir = dir_i;
          m_chain = chain_i;
          m_acc = 0;
          if (m_rem == 0) fin = 1; else m_busy = 1;
        end
      end else if (m_halt) begin
        if (err_clr_i) m_halt = 0;
      end else if (bus_err_i) begin
        m_halt = 1; m_err = 1;
      end else if (bus_ready_i) begin
        m_acc++;
        m_addr = m_addr + 4;
        if (m_addr == m_wrap) m_addr = m_base;
        if (m_rem <= 4) begin m_rem = 0; fin = 1; m_busy = 0; end
        else m_rem -= 4;
      end
      if (fin) begin
        if (m_chain) m_desc = 1; else m_done = 1;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h cyc=%0d", r, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    cyc++;
    chk(tag, busy_o, m_busy);
    chk(tag, bus_req_o, m_busy && !m_halt);
    chk("R5", done_irq_o, m_done);
    chk("R7", err_irq_o, m_err);
    chk("R6", desc_req_o, m_desc);
    if (m_busy && !m_halt) begin
      chk(tag, bus_addr_o, m_addr);
      chk(tag, bus_write_o, m_dir);
    end
    bus_ready_i = (rdy_mode == 0) ? 1'b1 : (cyc % 3 != 0);
  endtask

  task automatic launch(input int cnt, input logic [31:0] sa, input logic [31:0] wa,
                        input bit d, input bit ch);
    count_i = 12'(cnt); start_addr_i = sa; wrap_addr_i = wa; dir_i = d; chain_i = ch;
    start_i = 1;
    tick();
    start_i = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy_o; i++) tick();
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tag = "R1";
    tick(); tick();
    chk("R1", {bus_req_o, busy_o, done_irq_o, err_irq_o, desc_req_o}, 0);
    rst_ni = 1;
    tick();
    chk("R1", {bus_req_o, busy_o, done_irq_o, err_irq_o, desc_req_o}, 0);

    // R2 R3 R4 R5: plain write, unaligned start
    tag = "R2";
    launch(16, 32'h0000_1003, 32'h0000_2000, 1, 0);
    chk("R2", bus_addr_o, 32'h0000_1000);
    chk("R2", bus_write_o, 1);
    tag = "R3";
    wait_idle();
    chk("R4", m_acc, 4);
    chk("R5", done_irq_o, 1);
    tick(); tick();
    chk("R5", done_irq_o, 1);
    done_clr_i = 1; tick(); done_clr_i = 0; tick();
    chk("R5", done_irq_o, 0);

    // R3 R10: read with wrap and stalls
    tag = "R10";
    rdy_mode = 1;
    launch(20, 32'h0000_0102, 32'h0000_010B, 0, 0);
    chk("R2", bus_write_o, 0);
    wait_idle();
    chk("R3", m_acc, 5);
    rdy_mode = 0;
    done_clr_i = 1; tick(); done_clr_i = 0;

    // R4: zero count, both modes
    tag = "R4";
    launch(0, 32'h40, 32'h80, 1, 0);
    chk("R4", bus_req_o, 0);
    chk("R4", done_irq_o, 1);
    done_clr_i = 1; tick(); done_clr_i = 0;
    launch(0, 32'h40, 32'h80, 1, 1);
    chk("R6", desc_req_o, 1);
    chk("R6", done_irq_o, 0);
    tick();
    chk("R6", desc_req_o, 0);

    // R6: chained completion, R4 rounding
    tag = "R6";
    launch(6, 32'h300, 32'h400, 0, 1);
    wait_idle();
    chk("R4", m_acc, 2);
    chk("R6", desc_req_o, 1);
    tick();
    chk("R6", desc_req_o, 0);
    chk("R6", done_irq_o, 0);

    // R7 R8 R9: error with ready high, start while halted, replay
    tag = "R7";
    launch(16, 32'h200, 32'h1000, 1, 0);
    for (int i = 0; i < 20 && !(bus_req_o && bus_addr_o == 32'h204); i++) tick();
    bus_err_i = 1; bus_ready_i = 1;
    tick();
    bus_err_i = 0;
    chk("R7", bus_req_o, 0);
    chk("R7", err_irq_o, 1);
    chk("R7", bus_addr_o, 32'h204);
    tag = "R9";
    count_i = 12'd4; start_addr_i = 32'h900; start_i = 1;
    tick(); tick();
    start_i = 0;
    chk("R9", bus_req_o, 0);
    chk("R9", bus_addr_o, 32'h204);
    tag = "R8";
    err_clr_i = 1; tick(); err_clr_i = 0;
    chk("R8", bus_req_o, 1);
    chk("R8", bus_addr_o, 32'h204);
    chk("R8", bus_write_o, 1);
    chk("R8", err_irq_o, 0);
    wait_idle();
    chk("R8", m_acc, 4);

    // R5: completion and clear in the same cycle
    tag = "R5";
    done_clr_i = 1; tick(); done_clr_i = 0;
    launch(4, 32'h500, 32'h600, 0, 0);
    done_clr_i = 1;
    tick();
    done_clr_i = 0;
    chk("R5", done_irq_o, 1);
    chk("R5", busy_o, 0);
    tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule